// File: doc/BRIEF.md
# Register-to-Memory Store Unit with Fault Detection

This block executes store operations on behalf of a processor pipeline. A request names an operation (ordinal or integer byte, ordinal or integer short, or word, double-word, triple-word or quad-word), a base register index, the contents of that base register and an effective byte address. The unit turns the request into one or more 32-bit write beats on a valid/ready memory write port, each carrying byte enables. For multi-word operations it fetches each later register through a combinational register-file read port.

Before any beat is sent, the unit decides whether the store is legal. It checks three things: the base-register alignment that multi-word operations need, writes into a protected on-chip RAM window, and signed narrow values that do not fit their width. An illegal store writes nothing. A misaligned word store is different: it writes first and then reports its fault. Completion is a one-cycle pulse that carries a fault code.

The unit takes one request at a time. It is ready only when idle. Address generation, the register file, caches and fault handling sit outside the block.

Top module: `store_unit`

## Requirements
- R1: An ordinal or integer byte store (op 0 or 1) issues one beat at word address addr with bits [1:0] cleared. The beat carries bits [7:0] of the register in byte lane addr[1:0], zeros in the other lanes, and byte enable 1<<addr[1:0]. A short store (op 2 or 3) places bits [15:0] in lanes 0-1 (enable 4'b0011) when addr[1]=0, or in lanes 2-3 (enable 4'b1100) when addr[1]=1. addr[0] is ignored for shorts.
- R2: Ordinal narrow stores (op 0, op 2) drop the upper bits of the register and never report a fault.
- R3: An integer byte store (op 1) whose register is outside -128..127, or an integer short store (op 3) whose register is outside -32768..32767, issues no beat and completes with fault code 1.
- R4: An integer narrow store whose value is in range writes exactly as in R1 and completes with fault code 0.
- R5: Word, long, triple and quad stores (op 4..7) issue 1, 2, 3 and 4 beats with all byte enables set. Beat k goes to the cleared-low-bits address plus 4k and carries register base+k. Beat 0 takes the request data and later beats take the read port at index base+k.
- R6: A long store with an odd base, or a triple or quad store whose base is not a multiple of four, issues no beat and completes with fault code 4.
- R7: A store whose address satisfies (addr & PROT_MASK) == PROT_BASE (default: addresses below 0x400) issues no beat and completes with fault code 2.
- R8: A word store with addr[1:0] != 0 while unalign_fault_en_i=1 still issues its beat, then completes with fault code 3.
- R9: With unalign_fault_en_i=0, a misaligned word store completes with fault code 0. Misaligned non-word stores never report fault code 3.
- R10: While mem_valid_o is high and mem_ready_i is low, mem_valid_o stays high and the address, data and enables hold.
- R11: req_ready_o is high only when idle. done_o is a single-cycle pulse. It comes one cycle after the last accepted beat, or one cycle after acceptance when no beat is issued.
- R12: Fault priority is base alignment (4), then protected region (2), then overflow (1), then misalignment (3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Store request present |
| req_ready_o | output | 1 | Unit idle and accepting a request |
| req_op_i | input | 3 | Operation: 0 ord byte, 1 int byte, 2 ord short, 3 int short, 4 word, 5 long, 6 triple, 7 quad |
| req_base_i | input | REG_IDX_W | Base register index |
| req_data_i | input | DATA_W | Contents of the base register |
| req_addr_i | input | ADDR_W | Effective byte address |
| unalign_fault_en_i | input | 1 | Report misaligned word stores |
| rf_raddr_o | output | REG_IDX_W | Register-file read index |
| rf_rdata_i | input | DATA_W | Register-file read data (combinational) |
| mem_valid_o | output | 1 | Write beat valid |
| mem_ready_i | input | 1 | Memory accepts the beat |
| mem_addr_o | output | ADDR_W | Word-aligned beat address |
| mem_wdata_o | output | DATA_W | Beat data |
| mem_be_o | output | DATA_W/8 | Byte enables |
| done_o | output | 1 | Completion pulse |
| fault_o | output | 3 | Fault code, valid with done_o: 0 none, 1 overflow, 2 mismatch, 3 unaligned, 4 invalid operand |

## Verification
Some faults in the design show up in the same cycle as the error. A wrong fault decision at acceptance reaches the ports one cycle later, either as a beat where none belongs or as a wrong code on the done pulse. A corrupted beat counter shows at once as a wrong address, data or enable on the next beat, or as a missing or extra beat before done. Other faults only show under particular traffic. A sequencer that moves on while the memory stalls shows only when mem_ready_i is withheld, so random back-pressure is mixed into every store. Lane and priority errors need the directed boundary values of each signed range and stores that violate more than one rule at a time.

// File: rtl/store_pkg.sv
package store_pkg;
  typedef enum logic [2:0] {
    OP_ORD_B = 3'd0,
    OP_INT_B = 3'd1,
    OP_ORD_S = 3'd2,
    OP_INT_S = 3'd3,
    OP_WORD  = 3'd4,
    OP_LONG  = 3'd5,
    OP_TRIP  = 3'd6,
    OP_QUAD  = 3'd7
  } st_op_e;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_OVF      = 3'd1,
    FLT_MISMATCH = 3'd2,
    FLT_UNALIGN  = 3'd3,
    FLT_OPERAND  = 3'd4
  } st_fault_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SEND,
    SQ_FIN
  } sq_state_e;

  localparam int MAX_BEATS = 4;
  localparam int BEAT_W    = $clog2(MAX_BEATS);
endpackage

// File: rtl/store_check.sv
module store_check import store_pkg::*; #(
  parameter int REG_IDX_W = 5,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] PROT_BASE = '0,
  parameter logic [ADDR_W-1:0] PROT_MASK = 32'hFFFF_FC00
) (
  input  st_op_e                 op_i,
  input  logic [REG_IDX_W-1:0]   base_i,
  input  logic [DATA_W-1:0]      data_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   unalign_en_i,
  output st_fault_e              fault_o,
  output logic                   suppress_o,
  output logic [BEAT_W-1:0]      last_beat_o
);
  localparam int LANE_W = $clog2(DATA_W / 8);

  logic base_bad, in_prot, ovf, unal;

  always_comb begin
    base_bad = ((op_i == OP_LONG) && base_i[0]) ||
               (((op_i == OP_TRIP) || (op_i == OP_QUAD)) && (base_i[1:0] != 2'b00));
    in_prot  = (addr_i & PROT_MASK) == PROT_BASE;
    unique case (op_i)
      OP_INT_B: ovf = data_i != {{(DATA_W-8){data_i[7]}}, data_i[7:0]};
      OP_INT_S: ovf = data_i != {{(DATA_W-16){data_i[15]}}, data_i[15:0]};
      default:  ovf = 1'b0;
    endcase
    unal = (op_i == OP_WORD) && unalign_en_i && (addr_i[LANE_W-1:0] != '0);

    // R12: ordering of fault causes
    if (base_bad)     fault_o = FLT_OPERAND;
    else if (in_prot) fault_o = FLT_MISMATCH;
    else if (ovf)     fault_o = FLT_OVF;
    else if (unal)    fault_o = FLT_UNALIGN;
    else              fault_o = FLT_NONE;
    suppress_o = base_bad || in_prot || ovf;

    unique case (op_i)
      OP_LONG: last_beat_o = BEAT_W'(1);
      OP_TRIP: last_beat_o = BEAT_W'(2);
      OP_QUAD: last_beat_o = BEAT_W'(3);
      default: last_beat_o = '0;
    endcase
  end
endmodule

// File: rtl/store_lane.sv
module store_lane import store_pkg::*; #(
  parameter int DATA_W = 32,
  localparam int BE_W = DATA_W / 8,
  localparam int LANE_W = $clog2(BE_W)
) (
  input  st_op_e              op_i,
  input  logic [LANE_W-1:0]   lane_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic [DATA_W-1:0]   wdata_o,
  output logic [BE_W-1:0]     be_o
);
  logic [LANE_W-2:0] half;
  assign half = lane_i[LANE_W-1:1];

  always_comb begin
    unique case (op_i)
      OP_ORD_B, OP_INT_B: begin
        wdata_o = DATA_W'(data_i[7:0]) << (8 * lane_i);
        be_o    = BE_W'(1) << lane_i;
      end
      OP_ORD_S, OP_INT_S: begin
        wdata_o = DATA_W'(data_i[15:0]) << (16 * half);
        be_o    = BE_W'(2'b11) << (2 * half);
      end
      default: begin
        wdata_o = data_i;
        be_o    = '1;
      end
    endcase
  end
endmodule

// File: rtl/store_seq.sv
module store_seq import store_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               suppress_i,
  input  logic [BEAT_W-1:0]  last_beat_i,
  input  st_fault_e          fault_i,
  input  logic               mem_ready_i,
  output logic               idle_o,
  output logic               send_o,
  output logic [BEAT_W-1:0]  beat_o,
  output logic               done_o,
  output st_fault_e          fault_o
);
  sq_state_e         state_q;
  logic [BEAT_W-1:0] beat_q, last_q;
  st_fault_e         fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      beat_q  <= '0;
      last_q  <= '0;
      fault_q <= FLT_NONE;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (start_i) begin
          fault_q <= fault_i;
          last_q  <= last_beat_i;
          beat_q  <= '0;
          state_q <= suppress_i ? SQ_FIN : SQ_SEND;
        end
        SQ_SEND: if (mem_ready_i) begin
          if (beat_q == last_q) state_q <= SQ_FIN;
          else                  beat_q  <= beat_q + BEAT_W'(1);
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign idle_o  = state_q == SQ_IDLE;
  assign send_o  = state_q == SQ_SEND;
  assign done_o  = state_q == SQ_FIN;
  assign beat_o  = beat_q;
  assign fault_o = fault_q;

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !send_o && !done_o);
  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_o |-> fault_q != FLT_OVF);
  assert_no_mismatch_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_o |-> fault_q != FLT_MISMATCH);
  assert_no_bad_base_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_o |-> fault_q != FLT_OPERAND);
endmodule

// File: rtl/store_unit.sv
module store_unit import store_pkg::*; #(
  parameter int REG_IDX_W = 5,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] PROT_BASE = '0,
  parameter logic [ADDR_W-1:0] PROT_MASK = 32'hFFFF_FC00,
  localparam int BE_W = DATA_W / 8,
  localparam int LANE_W = $clog2(BE_W)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [2:0]            req_op_i,
  input  logic [REG_IDX_W-1:0]  req_base_i,
  input  logic [DATA_W-1:0]     req_data_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic                  unalign_fault_en_i,
  output logic [REG_IDX_W-1:0]  rf_raddr_o,
  input  logic [DATA_W-1:0]     rf_rdata_i,
  output logic                  mem_valid_o,
  input  logic                  mem_ready_i,
  output logic [ADDR_W-1:0]     mem_addr_o,
  output logic [DATA_W-1:0]     mem_wdata_o,
  output logic [BE_W-1:0]       mem_be_o,
  output logic                  done_o,
  output logic [2:0]            fault_o
);
  st_op_e                op_in, op_q;
  logic [REG_IDX_W-1:0]  base_q;
  logic [DATA_W-1:0]     data_q, beat_data;
  logic [ADDR_W-1:0]     addr_q;
  st_fault_e             chk_fault, seq_fault;
  logic                  chk_suppress, idle, accept;
  logic [BEAT_W-1:0]     chk_last, beat;

  assign op_in  = st_op_e'(req_op_i);
  assign accept = req_valid_i && idle;

  store_check #(
    .REG_IDX_W(REG_IDX_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .PROT_BASE(PROT_BASE), .PROT_MASK(PROT_MASK)
  ) i_check (
    .op_i(op_in), .base_i(req_base_i), .data_i(req_data_i), .addr_i(req_addr_i),
    .unalign_en_i(unalign_fault_en_i), .fault_o(chk_fault),
    .suppress_o(chk_suppress), .last_beat_o(chk_last)
  );

  store_seq i_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(accept), .suppress_i(chk_suppress),
    .last_beat_i(chk_last), .fault_i(chk_fault), .mem_ready_i(mem_ready_i),
    .idle_o(idle), .send_o(mem_valid_o), .beat_o(beat), .done_o(done_o),
    .fault_o(seq_fault)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_ORD_B;
      base_q <= '0;
      data_q <= '0;
      addr_q <= '0;
    end else if (accept) begin
      op_q   <= op_in;
      base_q <= req_base_i;
      data_q <= req_data_i;
      addr_q <= req_addr_i;
    end
  end

  assign rf_raddr_o = base_q + REG_IDX_W'(beat);
  assign beat_data  = (beat == '0) ? data_q : rf_rdata_i;
  assign mem_addr_o = {addr_q[ADDR_W-1:LANE_W], LANE_W'(0)} + (ADDR_W'(beat) << LANE_W);

  store_lane #(.DATA_W(DATA_W)) i_lane (
    .op_i(op_q), .lane_i(addr_q[LANE_W-1:0]), .data_i(beat_data),
    .wdata_o(mem_wdata_o), .be_o(mem_be_o)
  );

  assign req_ready_o = idle;
  assign fault_o     = seq_fault;

  assert_stall_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o)
      && $stable(mem_wdata_o) && $stable(mem_be_o));
  assert_addr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mem_valid_o && mem_ready_i) && mem_valid_o |->
      mem_addr_o == $past(mem_addr_o) + ADDR_W'(BE_W));
  assert_narrow_be_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && (op_q inside {OP_ORD_B, OP_INT_B}) |-> $onehot0(mem_be_o) && mem_be_o != '0);
  assert_wide_be_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && (op_q inside {OP_WORD, OP_LONG, OP_TRIP, OP_QUAD}) |-> mem_be_o == '1);
  assert_no_accept_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> !req_ready_o);
endmodule

// File: tb/test_store_unit.sv
module test_store_unit;
  localparam int RW = 5;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid_i = 0, req_ready_o;
  logic [2:0]  req_op_i = 0;
  logic [RW-1:0] req_base_i = 0;
  logic [31:0] req_data_i = 0, req_addr_i = 0;
  logic        unalign_fault_en_i = 0;
  logic [RW-1:0] rf_raddr_o;
  logic [31:0] rf_rdata_i;
  logic        mem_valid_o, mem_ready_i = 0;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [3:0]  mem_be_o;
  logic        done_o;
  logic [2:0]  fault_o;

  logic [31:0] rf [32];
  assign rf_rdata_i = rf[rf_raddr_o];

  store_unit i_store_unit (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_op_i(req_op_i), .req_base_i(req_base_i), .req_data_i(req_data_i),
    .req_addr_i(req_addr_i), .unalign_fault_en_i(unalign_fault_en_i),
    .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i), .mem_valid_o(mem_valid_o),
    .mem_ready_i(mem_ready_i), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_be_o(mem_be_o), .done_o(done_o), .fault_o(fault_o)
  );

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  logic [31:0] e_addr [4];
  logic [31:0] e_data [4];
  logic [3:0]  e_be [4];
  int          e_n;
  logic [2:0]  e_flt;

  task automatic calc(input logic [2:0] op, input logic [4:0] base,
                      input logic [31:0] addr, input bit ufe);
    logic [31:0] d;
    bit bb, pr, ov, un;
    d  = rf[base];
    bb = (op == 5 && base[0]) || ((op == 6 || op == 7) && base[1:0] != 0);
    pr = addr < 32'h400;
    ov = (op == 1 && ($signed(d) > 127 || $signed(d) < -128)) ||
         (op == 3 && ($signed(d) > 32767 || $signed(d) < -32768));
    un = op == 4 && ufe && addr[1:0] != 0;
    e_flt = bb ? 3'd4 : pr ? 3'd2 : ov ? 3'd1 : un ? 3'd3 : 3'd0;
    e_n = (bb || pr || ov) ? 0 : (op < 4 ? 1 : int'(op) - 3);
    for (int k = 0; k < 4; k++) begin
      e_addr[k] = {addr[31:2], 2'b00} + 32'(4 * k);
      if (op < 2) begin
        e_data[k] = {24'd0, d[7:0]} << (8 * addr[1:0]);
        e_be[k]   = 4'b0001 << addr[1:0];
      end else if (op < 4) begin
        e_data[k] = addr[1] ? {d[15:0], 16'd0} : {16'd0, d[15:0]};
        e_be[k]   = addr[1] ? 4'b1100 : 4'b0011;
      end else begin
        e_data[k] = rf[5'(base + 5'(k))];
        e_be[k]   = 4'b1111;
      end
    end
  endtask

  function automatic string tag_for(input logic [2:0] op);
    case (e_flt)
      3'd4: return "R6";
      3'd2: return "R7";
      3'd1: return "R3";
      3'd3: return "R8";
      default: return (op == 0 || op == 2) ? "R2" : (op < 4) ? "R4" : (op == 4) ? "R9" : "R5";
    endcase
  endfunction

  task automatic do_store(input logic [2:0] op, input logic [4:0] base,
                          input logic [31:0] addr, input bit ufe,
                          input int rdy_pct, input string tag_in);
    string tag, btag;
    int got, last_hs, exp_cyc;
    bit done_seen, prev_stall;
    logic [31:0] s_addr, s_data;
    logic [3:0] s_be;
    calc(op, base, addr, ufe);
    tag  = (tag_in != "") ? tag_in : tag_for(op);
    btag = (op < 4) ? "R1" : "R5";
    @(negedge clk);
    chk(req_ready_o == 1'b1, "R11", "ready when idle", 32'(req_ready_o), 32'd1);
    req_valid_i = 1; req_op_i = op; req_base_i = base; req_data_i = rf[base];
    req_addr_i = addr; unalign_fault_en_i = ufe;
    @(negedge clk);
    req_valid_i = 0;
    got = 0; last_hs = -1; done_seen = 0; prev_stall = 0;
    s_addr = 0; s_data = 0; s_be = 0;
    for (int cyc = 0; cyc < 64 && !done_seen; cyc++) begin
      if (cyc > 0) @(negedge clk);
      mem_ready_i = (int'($urandom % 100) < rdy_pct);
      if (prev_stall)
        chk(mem_valid_o && mem_addr_o == s_addr && mem_wdata_o == s_data && mem_be_o == s_be,
            "R10", "hold under stall", mem_wdata_o, s_data);
      if (done_o) begin
        done_seen = 1;
        chk(fault_o == e_flt, tag, "fault code", 32'(fault_o), 32'(e_flt));
        chk(got == e_n, tag, "beat count", 32'(got), 32'(e_n));
        exp_cyc = (e_n == 0) ? 0 : last_hs + 1;
        chk(cyc == exp_cyc, "R11", "done timing", 32'(cyc), 32'(exp_cyc));
        prev_stall = 0;
      end else if (mem_valid_o) begin
        if (got < e_n) begin
          chk(mem_addr_o == e_addr[got], btag, "beat addr", mem_addr_o, e_addr[got]);
          chk(mem_wdata_o == e_data[got], btag, "beat data", mem_wdata_o, e_data[got]);
          chk(mem_be_o == e_be[got], btag, "beat enables", 32'(mem_be_o), 32'(e_be[got]));
        end else if (mem_ready_i) begin
          chk(0, tag, "unexpected beat", mem_addr_o, 32'(e_n));
        end
        if (mem_ready_i) begin got++; last_hs = cyc; end
        prev_stall = !mem_ready_i;
        s_addr = mem_addr_o; s_data = mem_wdata_o; s_be = mem_be_o;
      end else prev_stall = 0;
    end
    if (!done_seen) chk(0, tag, "no done", 32'd0, 32'd1);
    @(negedge clk);
    mem_ready_i = 0;
    chk(!done_o && req_ready_o, "R11", "done one cycle", 32'(done_o), 32'd0);
  endtask

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog expired act=%h exp=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) rf[i] = 32'h1000_0000 + 32'(i * 32'h0101_0101);
    repeat (3) @(negedge clk);
    chk(req_ready_o == 1 && mem_valid_o == 0 && done_o == 0, "R11", "reset state",
        {29'd0, req_ready_o, mem_valid_o, done_o}, 32'h4);
    rst_ni = 1;

    // R1/R2 byte lanes, truncation
    rf[3] = 32'h1234_56A5;
    for (int l = 0; l < 4; l++) do_store(3'd0, 5'd3, 32'h0000_2000 + 32'(l), 1, 100, "R1");
    do_store(3'd2, 5'd3, 32'h0000_2001, 1, 100, "R1");
    do_store(3'd2, 5'd3, 32'h0000_2003, 1, 100, "R2");
    // R3/R4 signed boundaries
    rf[4] = 32'd127;        do_store(3'd1, 5'd4, 32'h3000, 0, 100, "R4");
    rf[4] = 32'd128;        do_store(3'd1, 5'd4, 32'h3000, 0, 100, "R3");
    rf[4] = 32'hFFFF_FF80;  do_store(3'd1, 5'd4, 32'h3001, 0, 100, "R4");
    rf[4] = 32'hFFFF_FF7F;  do_store(3'd1, 5'd4, 32'h3001, 0, 100, "R3");
    rf[4] = 32'h0000_7FFF;  do_store(3'd3, 5'd4, 32'h3002, 0, 100, "R4");
    rf[4] = 32'h0000_8000;  do_store(3'd3, 5'd4, 32'h3002, 0, 100, "R3");
    rf[4] = 32'hFFFF_8000;  do_store(3'd3, 5'd4, 32'h3000, 0, 100, "R4");
    // R6 base alignment
    do_store(3'd5, 5'd3, 32'h4000, 0, 100, "R6");
    do_store(3'd6, 5'd2, 32'h4000, 0, 100, "R6");
    do_store(3'd7, 5'd6, 32'h4000, 0, 100, "R6");
    do_store(3'd7, 5'd28, 32'h4000, 0, 100, "R5");
    do_store(3'd6, 5'd8, 32'h4004, 0, 40, "R10");
    // R7 protected window and R12 priority
    do_store(3'd4, 5'd0, 32'h0000_0100, 0, 100, "R7");
    do_store(3'd4, 5'd0, 32'h0000_03FC, 0, 100, "R7");
    rf[4] = 32'd500;       do_store(3'd1, 5'd4, 32'h0000_0010, 0, 100, "R12");
    do_store(3'd5, 5'd1, 32'h0000_0010, 0, 100, "R12");
    do_store(3'd4, 5'd0, 32'h0000_0102, 1, 100, "R12");
    // R8/R9 misaligned words
    do_store(3'd4, 5'd9, 32'h0000_5002, 1, 100, "R8");
    do_store(3'd4, 5'd9, 32'h0000_5001, 0, 100, "R9");
    do_store(3'd5, 5'd10, 32'h0000_5003, 1, 100, "R9");
    do_store(3'd0, 5'd10, 32'h0000_5003, 1, 100, "R9");

    for (int n = 0; n < 300; n++) begin
      logic [2:0] op;
      logic [4:0] base;
      logic [31:0] addr;
      for (int i = 0; i < 32; i++)
        rf[i] = ($urandom % 2) ? $urandom : 32'($signed(16'($urandom)) >>> ($urandom % 10));
      op   = 3'($urandom % 8);
      base = 5'($urandom % 32);
      if ($urandom % 3 != 0) base = (op == 5) ? {base[4:1], 1'b0} : (op > 5) ? {base[4:2], 2'b00} : base;
      addr = ($urandom % 5 == 0) ? ($urandom & 32'h3FF) : ($urandom | 32'h1000);
      do_store(op, base, addr, 1'($urandom % 2), 30 + int'($urandom % 71), "");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule